// File: doc/BRIEF.md
# Rewindable Synchronous FIFO

This block is a single-clock FIFO that sits in front of a bus-master write data path. Words are stored in a RAM array. A write pointer counter and a read pointer counter address the array. A pop copies the oldest word into a registered output, where it waits for the bus to accept it. If the target ends the transfer without taking that word, the master asserts `rewindEn`. The read pointer then steps back one entry, and the abandoned word becomes the head again, so the FIFO stays in step with the bus.

Some sources are prefetchable, and for those an early end needs no rewind. The master asserts `flushEn` instead, and everything left in the FIFO is discarded in a single clock. A combinational `headData` output shows the oldest word without removing it. A master that waits for acceptance before popping can use this and needs no rewind at all.

Each pointer has one more bit than the address needs. The extra wrap bit tells a full FIFO from an empty one. The FIFO also tracks how many popped words remain intact behind the read pointer. A rewind is honoured only while such a word still exists, which means a later push has not overwritten its slot.

Top module: `rewind_fifo`

## Requirements
- R1: While reset is asserted and just after it is released, `count` is 0, `empty` is 1, `full` is 0 and `dataOut` is 0.
- R2: An accepted pop loads the oldest stored word into `dataOut` on that clock edge. Words leave in the order they were pushed, and `dataOut` holds its value until the next accepted pop.
- R3: A push while `full` is 1 is discarded. A pop while `empty` is 1 is discarded, and both `count` and `dataOut` stay unchanged.
- R4: An accepted push alone raises `count` by one, and an accepted pop alone lowers it by one. A push and a pop in the same cycle, with the FIFO neither full nor empty, leave `count` unchanged.
- R5: An accepted rewind raises `count` by one. The next pop then returns the same word as the most recent pop.
- R6: A rewind is ignored in four cases: no popped word remains since reset or the last flush, the FIFO is full, `popEn` is asserted in the same cycle, or `flushEn` is asserted in the same cycle.
- R7: A push and a rewind in the same cycle raise `count` by two when at least two entries are free. If only one entry is free, the push is taken and the rewind is refused.
- R8: A flush makes the read pointer equal to the write pointer in one clock, so `empty` is 1 and `count` is 0 on the next cycle. A push, pop or rewind in the flush cycle is ignored, and the rewind history is cleared.
- R9: The words that can be rewound are limited to the popped words whose slots have not been overwritten by later pushes. That number never exceeds DEPTH minus `count`.
- R10: While `empty` is 0, `headData` equals the oldest stored word, and reading it removes nothing.
- R11: `full` is 1 exactly when `count` equals DEPTH. `count` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushEn | input | 1 | Store `pushData` at the tail |
| pushData | input | DATA_W | Word to store |
| popEn | input | 1 | Move the head word into `dataOut` |
| rewindEn | input | 1 | Step the read pointer back one entry |
| flushEn | input | 1 | Discard all stored words and history |
| dataOut | output | DATA_W | Registered word from the last accepted pop |
| headData | output | DATA_W | Oldest stored word, read without removal |
| count | output | $clog2(DEPTH)+1 | Number of stored words |
| full | output | 1 | FIFO holds DEPTH words |
| empty | output | 1 | FIFO holds no words |

## Verification
The hardest state to reach is a rewind request that must be refused because the popped word's slot has already been reused. This happens when a push and a rewind arrive with exactly one entry free, or after pushes have wrapped the write pointer onto slots behind the read pointer. Directed sequences fill the FIFO to one entry below full after a pop, issue push and rewind together, and then check which word the next pop returns. Long random runs mix pops, aborts and pushes at rates that keep the FIFO close to full. The bench model keeps a history queue trimmed to the free space, so every refused and every accepted rewind is predicted independently.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } fifoStrobe_t;
endpackage

// File: rtl/rewind_fifo_ctrl.sv
module rewind_fifo_ctrl
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pushEn,
  input  logic                       popEn,
  input  logic                       rewindEn,
  input  logic                       flushEn,
  output fifoStrobe_t                strobe,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] ONE_P   = PW'(1);
  localparam logic [PW-1:0] TWO_P   = PW'(2);

  logic [PW-1:0] wrPtr, rdPtr, histCnt;
  logic [PW-1:0] freeNow, wrNext, rdNext, histSum, freeNext;
  logic          pushOk, popOk, rewOk;

  // occupancy from the wrap-bit pointers
  assign count = wrPtr - rdPtr;
  assign full  = (count == DEPTH_P);
  assign empty = (count == '0);
  assign freeNow = DEPTH_P - count;

  always_comb begin
    pushOk = pushEn && !full && !flushEn;
    popOk  = popEn && !empty && !flushEn;
    // rewind needs an intact history word and room for it (plus the push)
    rewOk  = rewindEn && !popEn && !flushEn && (histCnt != '0) &&
             (freeNow >= (pushOk ? TWO_P : ONE_P));
    wrNext = wrPtr + PW'(pushOk);
    rdNext = rdPtr + PW'(popOk) - PW'(rewOk);
    histSum  = histCnt + PW'(popOk) - PW'(rewOk);
    freeNext = DEPTH_P - (wrNext - rdNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      histCnt <= '0;
    end else if (flushEn) begin
      rdPtr   <= wrPtr;
      histCnt <= '0;
    end else begin
      wrPtr   <= wrNext;
      rdPtr   <= rdNext;
      // history slots past the free space have been reused by pushes
      histCnt <= (histSum > freeNext) ? freeNext : histSum;
    end
  end

  assign strobe.wrEn = pushOk;
  assign strobe.rdEn = popOk;
  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];
endmodule

// File: rtl/rewind_fifo_data.sv
module rewind_fifo_data
  import rewind_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoStrobe_t                strobe,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  input  logic [DATA_W-1:0]          pushData,
  output logic [DATA_W-1:0]          dataOut,
  output logic [DATA_W-1:0]          headData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= pushData;
  end

  assign headData = mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataOut <= '0;
    else if (strobe.rdEn) dataOut <= mem[rdAddr];
  end
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pushEn,
  input  logic [DATA_W-1:0]        pushData,
  input  logic                     popEn,
  input  logic                     rewindEn,
  input  logic                     flushEn,
  output logic [DATA_W-1:0]        dataOut,
  output logic [DATA_W-1:0]        headData,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobe_t     strobe;
  logic [AW-1:0]   wrAddr, rdAddr;

  rewind_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
    .rewindEn(rewindEn), .flushEn(flushEn), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .count(count),
    .full(full), .empty(empty)
  );

  rewind_fifo_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .pushData(pushData), .dataOut(dataOut),
    .headData(headData)
  );
endmodule

// File: rtl/rewind_fifo_checker.sv
module rewind_fifo_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   pushEn,
  input logic                   popEn,
  input logic                   rewindEn,
  input logic                   flushEn,
  input logic [DATA_W-1:0]      dataOut,
  input logic [$clog2(DEPTH):0] count,
  input logic                   full,
  input logic                   empty
);
  localparam int PW = $clog2(DEPTH) + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    (count <= DEPTH_P) && !(full && empty));

  assert_pop_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && empty && !pushEn && !rewindEn && !flushEn) |=> ($stable(dataOut) && empty));

  assert_push_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && full && !popEn && !flushEn) |=> full);

  assert_push_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn && !full && !empty && !flushEn) |=> $stable(count));

  assert_rewind_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rewindEn && full && !popEn && !flushEn) |=> full);

  assert_rewind_room_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && rewindEn && !popEn && !flushEn && count == DEPTH_P - PW'(1)) |=> full);

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |=> (empty && count == '0));
endmodule

bind rewind_fifo rewind_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) checker_i (
  .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
  .rewindEn(rewindEn), .flushEn(flushEn), .dataOut(dataOut),
  .count(count), .full(full), .empty(empty)
);

// File: tb/rewind_fifo_tb_top.sv
module rewind_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushEn = 1'b0, popEn = 1'b0, rewindEn = 1'b0, flushEn = 1'b0;
  logic [DATA_W-1:0] pushData = '0;
  logic [DATA_W-1:0] dataOut, headData;
  logic [CW-1:0] count;
  logic full, empty;

  always #(CLK_PERIOD/2) clk = ~clk;

  rewind_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushData(pushData),
    .popEn(popEn), .rewindEn(rewindEn), .flushEn(flushEn),
    .dataOut(dataOut), .headData(headData), .count(count),
    .full(full), .empty(empty)
  );

  int nTests = 0;
  int nFail  = 0;
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] h[$];
  logic [DATA_W-1:0] expOut = '0;

  task automatic chk(string tag, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void modelStep(bit push, logic [DATA_W-1:0] d, bit pop, bit rew, bit fl);
    bit doPush, doPop, doRew;
    int freeNow;
    if (fl) begin
      q.delete();
      h.delete();
      return;
    end
    doPush  = push && (q.size() < DEPTH);
    doPop   = pop && (q.size() > 0);
    freeNow = DEPTH - q.size();
    doRew   = rew && !pop && (h.size() > 0) && (freeNow >= (doPush ? 2 : 1));
    if (doPop) begin
      expOut = q.pop_front();
      h.push_back(expOut);
    end
    if (doRew) q.push_front(h.pop_back());
    if (doPush) q.push_back(d);
    while (h.size() > DEPTH - q.size()) void'(h.pop_front());
  endfunction

  task automatic step(bit push, logic [DATA_W-1:0] d, bit pop, bit rew, bit fl);
    pushEn = push; pushData = d; popEn = pop; rewindEn = rew; flushEn = fl;
    @(posedge clk);
    modelStep(push, d, pop, rew, fl);
    #1;
    pushEn = 0; popEn = 0; rewindEn = 0; flushEn = 0;
    chk("R4 count", count, q.size());
    chk("R8 empty", empty, q.size() == 0);
    chk("R11 full", full, q.size() == DEPTH);
    chk("R2 dataOut", dataOut, expOut);
    if (q.size() > 0) chk("R10 headData", headData, q[0]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 dataOut", dataOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count after release", count, 0);

    // rewind with no history
    step(0, 0, 0, 1, 0);
    chk("R6 rewind without history", count, 0);

    for (int i = 0; i < DEPTH; i++) step(1, 16'h0100 + 16'(i), 0, 0, 0);
    chk("R11 full at depth", full, 1);
    step(1, 16'hDEAD, 0, 0, 0);
    chk("R3 push when full", count, DEPTH);
    chk("R10 head unchanged", headData, 16'h0100);

    step(0, 0, 1, 0, 0);
    chk("R2 first pop", dataOut, 16'h0100);
    step(0, 0, 0, 1, 0);
    chk("R5 rewind count", count, DEPTH);
    step(0, 0, 0, 1, 0);
    chk("R6 rewind when full", count, DEPTH);
    step(0, 0, 1, 0, 0);
    chk("R5 repop same word", dataOut, 16'h0100);

    // one free entry: push taken, rewind refused
    step(1, 16'h0200, 0, 1, 0);
    chk("R7 refused rewind count", count, DEPTH);
    step(0, 0, 1, 0, 0);
    chk("R7 next word not rewound", dataOut, 16'h0101);

    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R2 order", dataOut, 16'h0104);
    chk("R4 count after pops", count, 4);
    step(1, 16'h0201, 0, 1, 0);
    chk("R7 push plus rewind", count, 6);
    step(0, 0, 1, 1, 0);
    chk("R6 rewind with pop", count, 5);
    chk("R5 rewound word", dataOut, 16'h0104);

    step(1, 16'h0300, 1, 0, 0);
    chk("R4 push and pop", count, 5);

    step(1, 16'h0301, 1, 1, 1);
    chk("R8 flush empties", empty, 1);
    step(0, 0, 0, 1, 0);
    chk("R8 history cleared", count, 0);
    step(0, 0, 1, 0, 0);
    chk("R3 pop when empty", dataOut, 16'h0105);

    // history overwritten by later pushes
    for (int i = 0; i < 4; i++) step(1, 16'h0400 + 16'(i), 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0);
    for (int i = 0; i < 7; i++) step(1, 16'h0500 + 16'(i), 0, 0, 0);
    step(0, 0, 0, 1, 0);
    chk("R9 one intact word rewound", count, DEPTH);
    step(0, 0, 1, 0, 0);
    chk("R9 rewound newest popped", dataOut, 16'h0403);
    step(0, 0, 1, 0, 0);
    chk("R9 then pushed order", dataOut, 16'h0500);

    for (int n = 0; n < 4000; n++) begin
      int mode = n / 1000;
      bit p  = ($urandom_range(99) < (mode == 1 ? 70 : 50));
      bit o  = ($urandom_range(99) < (mode == 2 ? 65 : 45));
      bit r  = ($urandom_range(99) < 20);
      bit f  = ($urandom_range(99) < 2);
      step(p, 16'($urandom), o, r, f);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule